// File: doc/BRIEF.md
# Prioritized Broadcast Command Encoder

This block builds the 8-bit short broadcast words carried by a serial timing and control channel. It takes requests from several sources and keeps each one pending until it is sent. The sources are level-1 trigger decisions, front-end reset requests, calibration pulse requests, miscellaneous commands, and bunch-counter and event-counter resets. It then chooses which payload goes out in each word. The counter-reset bits always share the word with whatever payload is picked. When no payload is eligible, a counter reset goes out alone.

Trigger broadcasts that cannot be sent wait only until the channel is ready again. Reset, calibration and command requests that lose arbitration become ineligible until the next orbit strobe. A programmable number of idle cycles separates consecutive words. The channel-ready input stalls all transmission.

Top module: `bcast_cmd_enc`

## Requirements
- R1: After reset, bc_valid is 0 and bc_word is 8'h00; bc_word is 8'h00 in every cycle where bc_valid is 0.
- R2: A trigger word has bit 7 = 1, l1_type in bits 6:4 and l1_evid in bits 3:2.
- R3: A front-end reset word has bits 7:6 = 01, bit 5 = 0, and fer_flags[2:0] in bits 4:2 (bit 4 event-ID reset, bit 3 L1 front-end reset, bit 2 L0 front-end reset).
- R4: A calibration word has bits 7:4 = 0001 and cal_pulse in bits 3:2; a command word has bits 7:4 = 0000 and cmd_code in bits 3:2.
- R5: Bit 1 carries the event-counter reset and bit 0 the bunch-counter reset. Every pending counter reset is placed in the next word issued, alongside any payload.
- R6: When a counter reset is pending and no payload is eligible, a word is issued with bits 7:2 all zero.
- R7: Among eligible payloads, trigger wins over front-end reset, which wins over calibration, which wins over command.
- R8: A pending trigger stays pending while the channel is not ready or the gap has not elapsed. It is issued in the first cycle both allow.
- R9: A front-end reset, calibration or command that is eligible but not chosen when a word is issued becomes ineligible until an orbit strobe. An orbit strobe in the same cycle as the loss keeps it eligible.
- R10: No word is issued while chan_rdy is 0. Between two words bc_valid is low for at least gap_len cycles.
- R11: A request on a source that is already pending is ignored, and the held payload data is kept.
- R12: A request captured while the channel is free and the gap has elapsed appears with bc_valid high one cycle after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gap_len | input | GAP_W | Minimum idle cycles between words |
| chan_rdy | input | 1 | Channel can accept a word |
| orbit | input | 1 | Orbit boundary strobe |
| l1_req | input | 1 | Trigger broadcast request pulse |
| l1_type | input | 3 | Trigger type |
| l1_evid | input | 2 | Low event-ID bits |
| fer_req | input | 1 | Front-end reset request pulse |
| fer_flags | input | 3 | Reset flags {evid, L1 FE, L0 FE} |
| cal_req | input | 1 | Calibration request pulse |
| cal_pulse | input | 2 | Pulse type |
| cmd_req | input | 1 | Miscellaneous command request pulse |
| cmd_code | input | 2 | Command code |
| bcr_req | input | 1 | Bunch-counter reset request pulse |
| ecr_req | input | 1 | Event-counter reset request pulse |
| bc_valid | output | 1 | Word issued this cycle |
| bc_word | output | 8 | Broadcast word |

## Verification
Two events can fall in the same cycle: an orbit strobe, and the issue of a word in which an orbit-aligned request loses. The bench provokes this in a directed sequence and in random traffic where orbit strobes land on arbitration cycles. A cycle-accurate reference model in the bench decides whether the loser stays eligible, and the bench compares every output word. A second overlap is a counter reset pending while a payload is issued. The bench judges it on bits 1:0 of that same word.

// File: rtl/bce_pkg.sv
package bce_pkg;
   localparam int WORD_W  = 8;
   localparam int PAY_W   = 6;
   localparam int TYPE_W  = 3;
   localparam int EVID_W  = 2;
   localparam int FLAG_W  = 3;
   localparam int PULSE_W = 2;
   localparam int CODE_W  = 2;

   typedef logic [PAY_W-1:0] payload_t;

   function automatic payload_t pay_trig(input logic [TYPE_W-1:0] t, input logic [EVID_W-1:0] e);
      return {1'b1, t, e};
   endfunction

   function automatic payload_t pay_fer(input logic [FLAG_W-1:0] f);
      return {2'b01, 1'b0, f};
   endfunction

   function automatic payload_t pay_cal(input logic [PULSE_W-1:0] p);
      return {4'b0001, p};
   endfunction

   function automatic payload_t pay_cmd(input logic [CODE_W-1:0] c);
      return {4'b0000, c};
   endfunction
endpackage

// File: rtl/bce_gap.sv
module bce_gap #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [GAP_W-1:0] gap_len,
   output logic             open
);
   logic [GAP_W-1:0] cnt;

   if (GAP_W < 1) begin : g_bad_width
      $error("bce_gap: GAP_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (fire)          cnt <= gap_len;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign open = (cnt == '0);

   a_r10_quiet_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !fire);
   a_r10_gap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == $past(gap_len)));
endmodule

// File: rtl/bce_slot.sv
module bce_slot #(
   parameter int DW            = 2,
   parameter bit ORBIT_ALIGNED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [DW-1:0] din,
   input  logic          orbit,
   input  logic          fire,
   input  logic          win,
   output logic          elig,
   output logic [DW-1:0] dout
);
   logic pend;
   logic take;
   logic pend_nx;

   if (DW < 1) begin : g_bad_width
      $error("bce_slot: DW must be at least 1");
   end

   assign take    = req & ~pend;
   assign pend_nx = (pend & ~win) | take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         dout <= '0;
      end else begin
         pend <= pend_nx;
         if (take) dout <= din;
      end
   end

   a_r11_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !win) |=> $stable(dout));

   if (ORBIT_ALIGNED) begin : g_orbit
      logic armed;
      always_ff @(posedge clk) begin
         if (!rst_n)      armed <= 1'b0;
         else if (orbit)  armed <= pend_nx;
         else if (take)   armed <= 1'b1;
         else             armed <= armed & ~(fire & pend & ~win);
      end
      assign elig = pend & armed;

      a_r9_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(armed) |-> ($past(orbit) || $past(req)));
   end else begin : g_free
      logic unused_orbit_fire;
      assign unused_orbit_fire = orbit ^ fire;
      assign elig = pend;
   end
endmodule

// File: rtl/bcast_cmd_enc.sv
module bcast_cmd_enc
   import bce_pkg::*;
#(
   parameter int GAP_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GAP_W-1:0]   gap_len,
   input  logic               chan_rdy,
   input  logic               orbit,
   input  logic               l1_req,
   input  logic [TYPE_W-1:0]  l1_type,
   input  logic [EVID_W-1:0]  l1_evid,
   input  logic               fer_req,
   input  logic [FLAG_W-1:0]  fer_flags,
   input  logic               cal_req,
   input  logic [PULSE_W-1:0] cal_pulse,
   input  logic               cmd_req,
   input  logic [CODE_W-1:0]  cmd_code,
   input  logic               bcr_req,
   input  logic               ecr_req,
   output logic               bc_valid,
   output logic [WORD_W-1:0]  bc_word
);
   localparam int TRIG_DW = TYPE_W + EVID_W;

   if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
      $error("bcast_cmd_enc: GAP_W out of range");
   end

   logic                 t_el, r_el, c_el, k_el;
   logic                 t_win, r_win, c_win, k_win;
   logic [TRIG_DW-1:0]   t_dat;
   logic [FLAG_W-1:0]    r_dat;
   logic [PULSE_W-1:0]   c_dat;
   logic [CODE_W-1:0]    k_dat;
   logic                 bcr_p, ecr_p;
   logic                 gap_open, any_pay, fire;
   payload_t             pay;

   assign any_pay = t_el | r_el | c_el | k_el;
   assign fire    = chan_rdy & gap_open & (any_pay | bcr_p | ecr_p);
   assign t_win   = fire & t_el;
   assign r_win   = fire & ~t_el & r_el;
   assign c_win   = fire & ~t_el & ~r_el & c_el;
   assign k_win   = fire & ~t_el & ~r_el & ~c_el & k_el;

   bce_slot #(.DW(TRIG_DW), .ORBIT_ALIGNED(1'b0)) u_trig (
      .clk, .rst_n, .req(l1_req), .din({l1_type, l1_evid}), .orbit, .fire,
      .win(t_win), .elig(t_el), .dout(t_dat));
   bce_slot #(.DW(FLAG_W), .ORBIT_ALIGNED(1'b1)) u_fer (
      .clk, .rst_n, .req(fer_req), .din(fer_flags), .orbit, .fire,
      .win(r_win), .elig(r_el), .dout(r_dat));
   bce_slot #(.DW(PULSE_W), .ORBIT_ALIGNED(1'b1)) u_cal (
      .clk, .rst_n, .req(cal_req), .din(cal_pulse), .orbit, .fire,
      .win(c_win), .elig(c_el), .dout(c_dat));
   bce_slot #(.DW(CODE_W), .ORBIT_ALIGNED(1'b1)) u_cmd (
      .clk, .rst_n, .req(cmd_req), .din(cmd_code), .orbit, .fire,
      .win(k_win), .elig(k_el), .dout(k_dat));

   bce_gap #(.GAP_W(GAP_W)) u_gap (
      .clk, .rst_n, .fire, .gap_len, .open(gap_open));

   always_comb begin
      if (t_el)      pay = pay_trig(t_dat[TRIG_DW-1:EVID_W], t_dat[EVID_W-1:0]);
      else if (r_el) pay = pay_fer(r_dat);
      else if (c_el) pay = pay_cal(c_dat);
      else if (k_el) pay = pay_cmd(k_dat);
      else           pay = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcr_p    <= 1'b0;
         ecr_p    <= 1'b0;
         bc_valid <= 1'b0;
         bc_word  <= '0;
      end else begin
         bcr_p    <= (bcr_p & ~fire) | (bcr_req & ~bcr_p);
         ecr_p    <= (ecr_p & ~fire) | (ecr_req & ~ecr_p);
         bc_valid <= fire;
         bc_word  <= fire ? {pay, ecr_p, bcr_p} : '0;
      end
   end

   a_r5_ctr_rides: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && bcr_p) |=> (bc_valid && bc_word[0]));
   a_r7_trig_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && t_el) |=> bc_word[7]);
   a_r6_bare_ctr: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !any_pay) |=> (bc_word[7:2] == 6'd0));
   a_r10_needs_chan: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid |-> $past(chan_rdy));
endmodule

// File: tb/test_bcast_cmd_enc.sv
module test_bcast_cmd_enc;
   localparam int GAP_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [GAP_W-1:0] gap_len = '0;
   logic chan_rdy = 1'b1, orbit = 1'b0;
   logic l1_req = 1'b0; logic [2:0] l1_type = '0; logic [1:0] l1_evid = '0;
   logic fer_req = 1'b0; logic [2:0] fer_flags = '0;
   logic cal_req = 1'b0; logic [1:0] cal_pulse = '0;
   logic cmd_req = 1'b0; logic [1:0] cmd_code = '0;
   logic bcr_req = 1'b0, ecr_req = 1'b0;
   logic bc_valid; logic [7:0] bc_word;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   bcast_cmd_enc #(.GAP_W(GAP_W)) i_bcast_cmd_enc (
      .clk, .rst_n, .gap_len, .chan_rdy, .orbit, .l1_req, .l1_type, .l1_evid,
      .fer_req, .fer_flags, .cal_req, .cal_pulse, .cmd_req, .cmd_code,
      .bcr_req, .ecr_req, .bc_valid, .bc_word);

   // reference model state
   logic m_tp; logic [4:0] m_td;
   logic m_rp, m_ra; logic [2:0] m_rd;
   logic m_cp, m_ca; logic [1:0] m_cd;
   logic m_kp, m_ka; logic [1:0] m_kd;
   logic m_bcr, m_ecr; int m_gap;
   logic exp_v; logic [7:0] exp_w;

   task automatic model_clear();
      m_tp = 0; m_td = 0; m_rp = 0; m_ra = 0; m_rd = 0; m_cp = 0; m_ca = 0; m_cd = 0;
      m_kp = 0; m_ka = 0; m_kd = 0; m_bcr = 0; m_ecr = 0; m_gap = 0; exp_v = 0; exp_w = 0;
   endtask

   function automatic logic arm_next(logic p, logic a, logic rq, logic el, logic win, logic f);
      logic pn = (p & ~win) | (rq & ~p);
      if (orbit) return pn;
      if (rq && !p) return 1'b1;
      return a & ~(f & el & ~win);
   endfunction

   task automatic model_step();
      logic t_el, r_el, c_el, k_el, f, wt, wr, wc, wk;
      logic [5:0] pay;
      t_el = m_tp; r_el = m_rp & m_ra; c_el = m_cp & m_ca; k_el = m_kp & m_ka;
      f = chan_rdy && (m_gap == 0) && (t_el || r_el || c_el || k_el || m_bcr || m_ecr);
      if (t_el)      pay = {1'b1, m_td};
      else if (r_el) pay = {3'b010, m_rd};
      else if (c_el) pay = {4'b0001, m_cd};
      else if (k_el) pay = {4'b0000, m_kd};
      else           pay = 6'd0;
      wt = f & t_el; wr = f & !t_el & r_el; wc = f & !t_el & !r_el & c_el;
      wk = f & !t_el & !r_el & !c_el & k_el;
      exp_v = f;
      exp_w = f ? {pay, m_ecr, m_bcr} : 8'h00;
      m_gap = f ? int'(gap_len) : (m_gap > 0 ? m_gap - 1 : 0);
      m_ra = arm_next(m_rp, m_ra, fer_req, r_el, wr, f);
      m_ca = arm_next(m_cp, m_ca, cal_req, c_el, wc, f);
      m_ka = arm_next(m_kp, m_ka, cmd_req, k_el, wk, f);
      if (l1_req && !m_tp)  m_td = {l1_type, l1_evid};
      if (fer_req && !m_rp) m_rd = fer_flags;
      if (cal_req && !m_cp) m_cd = cal_pulse;
      if (cmd_req && !m_kp) m_kd = cmd_code;
      m_tp = (m_tp & ~wt) | (l1_req & ~m_tp);
      m_rp = (m_rp & ~wr) | (fer_req & ~m_rp);
      m_cp = (m_cp & ~wc) | (cal_req & ~m_cp);
      m_kp = (m_kp & ~wk) | (cmd_req & ~m_kp);
      m_bcr = (m_bcr & ~f) | (bcr_req & ~m_bcr);
      m_ecr = (m_ecr & ~f) | (ecr_req & ~m_ecr);
   endtask

   task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // one clock: model consumes current inputs, DUT updates, compare, drop pulses
   task automatic step();
      model_step();
      @(posedge clk);
      @(negedge clk);
      if (bc_valid !== exp_v)                 chk("R10 valid timing (model)", {8'h0, bc_valid}, {8'h0, exp_v});
      else if (bc_word[1:0] !== exp_w[1:0])   chk("R5 counter bits (model)", {1'b0, bc_word}, {1'b0, exp_w});
      else                                    chk("R7 payload (model)", {1'b0, bc_word}, {1'b0, exp_w});
      l1_req = 0; fer_req = 0; cal_req = 0; cmd_req = 0; bcr_req = 0; ecr_req = 0; orbit = 0;
   endtask

   function automatic logic [8:0] out9();
      return {bc_valid, bc_word};
   endfunction

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_fail++;
      $display("FAIL watchdog R1-timeout act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4321));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset state", out9(), 9'h000);

      // R2 + R12: trigger word one cycle after capture
      l1_req = 1; l1_type = 3'd5; l1_evid = 2'd2;
      step();
      chk("R12 not yet issued", out9(), 9'h000);
      step();
      chk("R2 trigger encoding", out9(), {1'b1, 8'hD8});

      // R3/R7/R9: reset beats calibration; calibration waits for orbit
      fer_req = 1; fer_flags = 3'b101; cal_req = 1; cal_pulse = 2'b11;
      step(); step();
      chk("R3 reset word", out9(), {1'b1, 8'h54});
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R9 loser waits for orbit", out9(), 9'h000);
      end
      orbit = 1; step(); step();
      chk("R4 calibration word after orbit R9", out9(), {1'b1, 8'h1C});

      // R6: bare bunch-counter reset
      bcr_req = 1; step(); step();
      chk("R6 bare counter reset", out9(), {1'b1, 8'h01});

      // R5: event-counter reset rides with trigger
      ecr_req = 1; l1_req = 1; l1_type = 3'd1; l1_evid = 2'd3;
      step(); step();
      chk("R5 counter rides with payload", out9(), {1'b1, 8'h9E});

      // R8/R11: channel stalled, second request ignored
      chan_rdy = 0;
      l1_req = 1; l1_type = 3'd2; l1_evid = 2'd0; step();
      l1_req = 1; l1_type = 3'd7; l1_evid = 2'd1; step();
      step();
      chk("R10 no word while channel busy", out9(), 9'h000);
      chan_rdy = 1; step();
      chk("R8 R11 deferred trigger keeps first data", out9(), {1'b1, 8'hA0});

      // R10: gap of 3 idle cycles
      gap_len = 8'd3;
      l1_req = 1; l1_type = 3'd0; l1_evid = 2'd0; step(); step();
      chk("R10 first spaced word", out9(), {1'b1, 8'h80});
      l1_req = 1; step(); chk("R10 gap cycle 1", out9(), 9'h000);
      step(); chk("R10 gap cycle 2", out9(), 9'h000);
      step(); chk("R10 gap cycle 3", out9(), 9'h000);
      step(); chk("R10 word after gap", out9(), {1'b1, 8'h80});
      gap_len = 8'd0;

      // R4: command word; R9: loss coinciding with orbit keeps eligibility
      repeat (4) step();
      cmd_req = 1; cmd_code = 2'b10; step(); step();
      chk("R4 command word", out9(), {1'b1, 8'h08});
      l1_req = 1; l1_type = 3'd3; l1_evid = 2'd1; cmd_req = 1; cmd_code = 2'b01; step();
      orbit = 1; step();
      chk("R7 trigger wins", out9(), {1'b1, 8'hB4});
      step();
      chk("R9 orbit same cycle keeps loser", out9(), {1'b1, 8'h04});

      // constrained random traffic against the model
      for (int ph = 0; ph < 6; ph++) begin
         gap_len = GAP_W'($urandom % 4);
         for (int c = 0; c < 500; c++) begin
            chan_rdy  = ($urandom % 8) != 0;
            orbit     = ($urandom % 30) == 0;
            l1_req    = ($urandom % 5) == 0; l1_type = 3'($urandom); l1_evid = 2'($urandom);
            fer_req   = ($urandom % 9) == 0; fer_flags = 3'($urandom);
            cal_req   = ($urandom % 9) == 0; cal_pulse = 2'($urandom);
            cmd_req   = ($urandom % 9) == 0; cmd_code = 2'($urandom);
            bcr_req   = ($urandom % 12) == 0;
            ecr_req   = ($urandom % 12) == 0;
            step();
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule